// File: doc/BRIEF.md
# Unaligned Load Byte Aligner

This unit sits between a processor load port and a memory that returns one 32-bit word per read and only accepts word addresses. A load names a byte address and a size of one, two or four bytes. The unit may start at any byte offset. When every requested byte lies inside one memory word, the unit issues a single read. When the bytes run past the end of a word, it issues two reads on back-to-back cycles, to the word and to the word after it. The bytes are then shifted into place, zero-filled above the requested size, and returned with a one-cycle completion pulse.

The memory port is a plain read strobe with a word address. Read data is valid on the cycle after the strobe. A request is accepted only while the unit reports ready. A size code that names no legal width is finished straight away with an error flag and causes no memory traffic. A load that spans two words costs one more cycle than a load that fits in one word.

Top module: `load_aligner`

## Requirements
- R1: During and straight after a synchronous reset, req_ready is 1, and mem_rd_en, rsp_done, rsp_illegal and rsp_data are all 0.
- R2: req_size code 0 loads 1 byte, code 1 loads 2 bytes and code 2 loads 4 bytes. The byte at the lowest address lands in rsp_data[7:0], each following address fills the next higher byte, and result bytes beyond the size are 0.
- R3: When byte offset (req_addr[1:0]) plus size is at most 4, exactly one read is issued, at word address req_addr[15:2], on the cycle after acceptance. rsp_done rises with the second rising edge after the accepting edge.
- R4: When offset plus size exceeds 4, exactly two reads are issued on consecutive cycles: first to the word address, then to that address plus one. rsp_done rises with the third rising edge after the accepting edge.
- R5: The second read address wraps modulo the word address space, so a load crossing the top word continues at word 0.
- R6: req_size code 3 is illegal. rsp_done and rsp_illegal rise together at the accepting edge, rsp_data is 0, and no read is issued.
- R7: From acceptance until the completion pulse, req_ready is 0 and requests on the request inputs are ignored.
- R8: rsp_done is a single-cycle pulse, req_ready is 0 while it is high, and rsp_illegal is only ever high together with rsp_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present |
| req_addr | input | 16 | Byte address of the load |
| req_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = illegal |
| req_ready | output | 1 | Unit idle; a request is taken at the next edge |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 14 | Word address of the read |
| mem_rd_data | input | 32 | Read data, valid the cycle after the strobe |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 32 | Assembled load value, zero-extended |
| rsp_illegal | output | 1 | Completed request had an illegal size |

## Verification
Byte loads at every offset show whether the shift amount is right for each lane. Half-word loads at offsets 1 and 3 separate the case of extracting middle bytes from one word from the case of stitching one byte from each of two words. Word loads at offsets 0 to 3 test the two-read merge with one, two and three bytes taken from the upper word, and a load at the top of the address space shows whether the next-word address wraps. An illegal size and a request held high while the unit is busy show that no read is issued and nothing extra is accepted.

// File: rtl/la_pkg.sv
package la_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } ld_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ1 = 2'd1,
    ST_GET1 = 2'd2,
    ST_GET2 = 2'd3
  } ld_state_e;

  function automatic logic [3:0] size_to_bytes(input ld_size_e sz);
    case (sz)
      SZ_BYTE: return 4'd1;
      SZ_HALF: return 4'd2;
      SZ_WORD: return 4'd4;
      default: return 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/la_decode.sv
module la_decode
  import la_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTES  = 4,
  localparam int OFF_W   = $clog2(BYTES),
  localparam int WADDR_W = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [1:0]         size,
  output logic [WADDR_W-1:0] waddr,
  output logic [OFF_W-1:0]   off,
  output logic [3:0]         nbytes,
  output logic               split,
  output logic               illegal
);
  localparam logic [4:0] LANES = 5'(BYTES);

  logic [4:0] end_pos;

  always_comb begin
    waddr   = addr[ADDR_W-1:OFF_W];
    off     = addr[OFF_W-1:0];
    nbytes  = size_to_bytes(ld_size_e'(size));
    illegal = (ld_size_e'(size) == SZ_BAD);
    end_pos = 5'(off) + 5'(nbytes);
    split   = !illegal && (end_pos > LANES);
  end

endmodule

// File: rtl/la_merge.sv
module la_merge #(
  parameter int BYTES = 4,
  localparam int DATA_W = BYTES * 8,
  localparam int OFF_W  = $clog2(BYTES)
) (
  input  logic [DATA_W-1:0] lo_word,
  input  logic [DATA_W-1:0] hi_word,
  input  logic [OFF_W-1:0]  off,
  input  logic [3:0]        nbytes,
  output logic [DATA_W-1:0] result
);
  logic [2*DATA_W-1:0] pair;
  logic [2*DATA_W-1:0] shifted;

  always_comb begin
    pair    = {hi_word, lo_word};
    shifted = pair >> {off, 3'b000};
  end

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    localparam logic [3:0] LANE = 4'(g);
    assign result[g*8 +: 8] = (LANE < nbytes) ? shifted[g*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/la_seq.sv
module la_seq
  import la_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTES  = 4,
  localparam int DATA_W  = BYTES * 8,
  localparam int OFF_W   = $clog2(BYTES),
  localparam int WADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [WADDR_W-1:0] dec_waddr,
  input  logic [OFF_W-1:0]   dec_off,
  input  logic [3:0]         dec_nbytes,
  input  logic               dec_split,
  input  logic               dec_illegal,
  input  logic [DATA_W-1:0]  mem_rd_data,
  input  logic [DATA_W-1:0]  merged,
  output logic               req_ready,
  output logic               mem_rd_en,
  output logic [WADDR_W-1:0] mem_rd_addr,
  output logic [DATA_W-1:0]  merge_lo,
  output logic [DATA_W-1:0]  merge_hi,
  output logic [OFF_W-1:0]   cur_off,
  output logic [3:0]         cur_nbytes,
  output logic               rsp_done,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               rsp_illegal
);
  ld_state_e         state;
  logic              split_q;
  logic [DATA_W-1:0] lo_q;

  assign req_ready = (state == ST_IDLE) && !rsp_done;

  always_comb begin
    if (state == ST_GET2) begin
      merge_lo = lo_q;
      merge_hi = mem_rd_data;
    end else begin
      merge_lo = mem_rd_data;
      merge_hi = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      cur_off     <= '0;
      cur_nbytes  <= '0;
      split_q     <= 1'b0;
      lo_q        <= '0;
      rsp_done    <= 1'b0;
      rsp_data    <= '0;
      rsp_illegal <= 1'b0;
    end else begin
      rsp_done    <= 1'b0;
      rsp_illegal <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            if (dec_illegal) begin
              rsp_done    <= 1'b1;
              rsp_illegal <= 1'b1;
              rsp_data    <= '0;
            end else begin
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= dec_waddr;
              cur_off     <= dec_off;
              cur_nbytes  <= dec_nbytes;
              split_q     <= dec_split;
              state       <= ST_REQ1;
            end
          end
        end
        ST_REQ1: begin
          if (split_q) begin
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= mem_rd_addr + 1'b1;
          end else begin
            mem_rd_en <= 1'b0;
          end
          state <= ST_GET1;
        end
        ST_GET1: begin
          mem_rd_en <= 1'b0;
          lo_q      <= mem_rd_data;
          if (split_q) begin
            state <= ST_GET2;
          end else begin
            rsp_done <= 1'b1;
            rsp_data <= merged;
            state    <= ST_IDLE;
          end
        end
        ST_GET2: begin
          rsp_done <= 1'b1;
          rsp_data <= merged;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/load_aligner.sv
module load_aligner #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int BYTES   = DATA_W / 8,
  localparam int OFF_W   = $clog2(BYTES),
  localparam int WADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [1:0]         req_size,
  output logic               req_ready,
  output logic               mem_rd_en,
  output logic [WADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0]  mem_rd_data,
  output logic               rsp_done,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               rsp_illegal
);
  logic [WADDR_W-1:0] dec_waddr;
  logic [OFF_W-1:0]   dec_off;
  logic [3:0]         dec_nbytes;
  logic               dec_split;
  logic               dec_illegal;
  logic [DATA_W-1:0]  merge_lo;
  logic [DATA_W-1:0]  merge_hi;
  logic [OFF_W-1:0]   cur_off;
  logic [3:0]         cur_nbytes;
  logic [DATA_W-1:0]  merged;

  la_decode #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_decode (
    .addr    (req_addr),
    .size    (req_size),
    .waddr   (dec_waddr),
    .off     (dec_off),
    .nbytes  (dec_nbytes),
    .split   (dec_split),
    .illegal (dec_illegal)
  );

  la_seq #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .dec_waddr   (dec_waddr),
    .dec_off     (dec_off),
    .dec_nbytes  (dec_nbytes),
    .dec_split   (dec_split),
    .dec_illegal (dec_illegal),
    .mem_rd_data (mem_rd_data),
    .merged      (merged),
    .req_ready   (req_ready),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .merge_lo    (merge_lo),
    .merge_hi    (merge_hi),
    .cur_off     (cur_off),
    .cur_nbytes  (cur_nbytes),
    .rsp_done    (rsp_done),
    .rsp_data    (rsp_data),
    .rsp_illegal (rsp_illegal)
  );

  la_merge #(.BYTES(BYTES)) u_merge (
    .lo_word (merge_lo),
    .hi_word (merge_hi),
    .off     (cur_off),
    .nbytes  (cur_nbytes),
    .result  (merged)
  );

endmodule

// File: rtl/la_check.sv
module la_check #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int BYTES   = DATA_W / 8,
  localparam int OFF_W   = $clog2(BYTES),
  localparam int WADDR_W = ADDR_W - OFF_W
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [1:0]         req_size,
  input logic               req_ready,
  input logic               mem_rd_en,
  input logic [WADDR_W-1:0] mem_rd_addr,
  input logic               rsp_done,
  input logic               rsp_illegal
);
  logic take;
  assign take = req_valid && req_ready;

  a_r3_first_read: assert property (@(posedge clk) disable iff (rst)
    take && (req_size != 2'd3) |=>
      mem_rd_en && (mem_rd_addr == $past(req_addr[ADDR_W-1:OFF_W])));

  a_r4_next_word: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en && $past(mem_rd_en) |->
      mem_rd_addr == WADDR_W'($past(mem_rd_addr) + 1'b1));

  a_r4_two_reads_max: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en && $past(mem_rd_en) |=> !mem_rd_en);

  a_r6_illegal_no_read: assert property (@(posedge clk) disable iff (rst)
    take && (req_size == 2'd3) |=> rsp_done && rsp_illegal && !mem_rd_en);

  a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> !req_ready);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  a_r8_illegal_with_done: assert property (@(posedge clk) disable iff (rst)
    rsp_illegal |-> rsp_done && !req_ready);

endmodule

bind load_aligner la_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_check (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_addr    (req_addr),
  .req_size    (req_size),
  .req_ready   (req_ready),
  .mem_rd_en   (mem_rd_en),
  .mem_rd_addr (mem_rd_addr),
  .rsp_done    (rsp_done),
  .rsp_illegal (rsp_illegal)
);

// File: tb/load_aligner_bench.sv
module load_aligner_bench;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 32;
  localparam int WADDR_W = 14;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst = 1'b1;
  logic               req_valid = 1'b0;
  logic [ADDR_W-1:0]  req_addr = '0;
  logic [1:0]         req_size = '0;
  logic               req_ready;
  logic               mem_rd_en;
  logic [WADDR_W-1:0] mem_rd_addr;
  logic [DATA_W-1:0]  mem_rd_data = '0;
  logic               rsp_done;
  logic [DATA_W-1:0]  rsp_data;
  logic               rsp_illegal;

  int checks = 0;
  int failures = 0;
  int rd_total = 0;
  logic [WADDR_W-1:0] rd_log [64];

  load_aligner #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_load_aligner (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_ready(req_ready), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .rsp_done(rsp_done), .rsp_data(rsp_data), .rsp_illegal(rsp_illegal)
  );

  function automatic logic [31:0] word_of(input logic [WADDR_W-1:0] w);
    logic [7:0] k;
    k = w[7:0] ^ {2'b00, w[13:8]};
    return {k ^ 8'hD3, k ^ 8'h96, k ^ 8'h5A, k ^ 8'h1E};
  endfunction

  function automatic logic [7:0] byte_at(input logic [ADDR_W-1:0] a);
    logic [31:0] w;
    w = word_of(a[ADDR_W-1:2]);
    return w[a[1:0]*8 +: 8];
  endfunction

  // one-cycle read latency memory model and read log
  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= word_of(mem_rd_addr);
      rd_log[rd_total % 64] <= mem_rd_addr;
      rd_total <= rd_total + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_load(input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                          input string req, input bit poke_busy);
    int n;
    int k;
    int base;
    int exp_reads;
    int exp_k;
    logic [31:0] exp_data;
    logic [WADDR_W-1:0] w0;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 0;
    exp_data = '0;
    for (int i = 0; i < n; i++) exp_data[i*8 +: 8] = byte_at(a + ADDR_W'(i));
    w0 = a[ADDR_W-1:2];
    if (n == 0) begin exp_reads = 0; exp_k = 0; end
    else if (int'(a[1:0]) + n > 4) begin exp_reads = 2; exp_k = 3; end
    else begin exp_reads = 1; exp_k = 2; end

    k = 0;
    while (!req_ready && k < 10) begin @(negedge clk); k++; end
    base = rd_total;
    req_valid = 1'b1; req_addr = a; req_size = sz;
    @(posedge clk);
    @(negedge clk);
    if (poke_busy) begin
      req_valid = 1'b1; req_addr = a ^ 16'h0404; req_size = 2'd3;
    end else begin
      req_valid = 1'b0;
    end
    k = 0;
    while (!rsp_done && k < 10) begin @(negedge clk); k++; end
    req_valid = 1'b0;

    check(rsp_done, req, "done seen", 32'(rsp_done), 32'd1);
    check(k == exp_k, req, "done latency edges", 32'(k), 32'(exp_k));
    check(rsp_data == exp_data, req, "data", rsp_data, exp_data);
    check(rsp_illegal == (n == 0), req, "illegal flag", 32'(rsp_illegal), 32'(n == 0));
    check(!req_ready, "R8", "ready low with done", 32'(req_ready), 32'd0);
    check(rd_total - base == exp_reads, req, "read count", 32'(rd_total - base), 32'(exp_reads));
    if (exp_reads >= 1)
      check(rd_log[base % 64] == w0, req, "first read addr",
            32'(rd_log[base % 64]), 32'(w0));
    if (exp_reads == 2)
      check(rd_log[(base + 1) % 64] == WADDR_W'(w0 + 1'b1), req, "second read addr",
            32'(rd_log[(base + 1) % 64]), 32'(WADDR_W'(w0 + 1'b1)));
    @(negedge clk);
    check(!rsp_done, "R8", "done is one pulse", 32'(rsp_done), 32'd0);
    check(rd_total - base == exp_reads, "R7", "no read after done",
          32'(rd_total - base), 32'(exp_reads));
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check(req_ready && !mem_rd_en && !rsp_done && !rsp_illegal && rsp_data == '0,
          "R1", "outputs during reset",
          {27'd0, req_ready, mem_rd_en, rsp_done, rsp_illegal, |rsp_data}, 32'h10);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready && !mem_rd_en && !rsp_done && rsp_data == '0,
          "R1", "outputs after reset",
          {28'd0, req_ready, mem_rd_en, rsp_done, |rsp_data}, 32'h8);
  endtask

  task automatic test_bytes();
    for (int o = 0; o < 4; o++) run_load(16'h0120 + 16'(o), 2'd0, "R2", 1'b0);
  endtask

  task automatic test_single_word();
    run_load(16'h0200, 2'd1, "R3", 1'b0);
    run_load(16'h0201, 2'd1, "R3", 1'b0);
    run_load(16'h0202, 2'd1, "R3", 1'b0);
    run_load(16'h0204, 2'd2, "R3", 1'b0);
  endtask

  task automatic test_crossing();
    run_load(16'h0303, 2'd1, "R4", 1'b0);
    run_load(16'h0311, 2'd2, "R4", 1'b0);
    run_load(16'h0322, 2'd2, "R4", 1'b0);
    run_load(16'h0333, 2'd2, "R4", 1'b0);
  endtask

  task automatic test_wrap();
    run_load(16'hFFFF, 2'd1, "R5", 1'b0);
    run_load(16'hFFFE, 2'd2, "R5", 1'b0);
  endtask

  task automatic test_illegal();
    run_load(16'h0407, 2'd3, "R6", 1'b0);
    run_load(16'h0400, 2'd2, "R6", 1'b0);
  endtask

  task automatic test_busy();
    run_load(16'h0503, 2'd2, "R7", 1'b1);
    run_load(16'h0510, 2'd0, "R7", 1'b1);
  endtask

  initial begin
    test_reset();
    test_bytes();
    test_single_word();
    test_crossing();
    test_wrap();
    test_illegal();
    test_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule